// File: doc/BRIEF.md
# MDIO Command Register Bridge

This block lets software reach the management registers of Ethernet PHYs through one 32-bit command register. A single write to the register gives all the fields of a transaction: the go flag, the direction, the PHY address, the register address and, for a write, the 16-bit value. The bridge then sends a clause-22 management frame on the MDC/MDIO pins. MDC is a divided copy of the system clock.

For a read, the bridge releases MDIO from the turnaround onward. It takes the 16 bits the PHY returns on rising MDC edges and stores them in the low half of the same register. Bit 31 reads back as 1 for as long as the frame runs and clears by itself at the end, so software polls that bit to see when the transaction is done. The MDIO pad is split into output, output enable and input, so the tri-state buffer sits outside the block.

Top module: `mdio_cmd_bridge`

## Requirements
- R1: After reset the command register reads 0x00000000, MDC is low and MDIO is not driven (output enable low).
- R2: A write with bit 31 set while idle stores the word and starts a transaction. Bit 31 reads 1 for exactly 64 x 2 x HALF_DIV clock cycles, starting the cycle after the write, and then reads 0. A write transaction leaves bits 30:0 as written.
- R3: Every frame goes out MSB first, one bit per MDC period. The order is 32 ones, then 0,1, then the opcode, then the PHY address from bits 25:21, then the register address from bits 20:16. The opcode is 0,1 when bit 30 = 1 (write) and 1,0 when bit 30 = 0 (read).
- R4: In a write frame the turnaround bits are 1,0 and are followed by bits 15:0 MSB first. MDIO is driven for all 64 bit periods.
- R5: In a read frame MDIO is driven for bit periods 0 to 45 and released for bit periods 46 to 63.
- R6: In a read frame the bridge samples MDIO on the rising MDC edge of bit periods 48 to 63, MSB first. At completion the 16 bits land in bits 15:0, and bits 30:16 are kept.
- R7: Each bit period is HALF_DIV clocks with MDC low, then HALF_DIV clocks with MDC high. MDC is low while idle. The MDIO output changes only when MDC falls.
- R8: A write to the register while a transaction is in progress is ignored. The register contents and the frame on the pins are not affected.
- R9: A write with bit 31 clear while idle only stores the word. No frame starts: MDC stays low and MDIO stays released.
- R10: The MDIO input has no effect outside the read data window. Write frames and the stored result do not depend on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the command register |
| regWrData | input | 32 | Write data for the command register |
| regRdData | output | 32 | Current command register contents |
| mdc | output | 1 | Management clock to the PHYs |
| mdioOut | output | 1 | MDIO value when driven |
| mdioOe | output | 1 | MDIO output enable (1 = drive) |
| mdioIn | input | 1 | MDIO value seen at the pad |

## Verification
A bench model steps alongside the design on every clock and predicts MDC, the output enable, the driven bit and the register word. It is exercised with a write frame carrying a typical PHY control value, a write frame with every field at all ones, and read frames from several PHY and register addresses. The PHY in those reads returns a mixed pattern, all zeros and all ones, which tells a correct MSB-first capture apart from shifted, reversed or stuck data. A command word with the go bit clear separates storing from starting. A second command issued mid-frame shows whether the busy lock holds. While a frame is being sent, the MDIO input toggles every cycle, which exposes any sampling outside the read data window.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  localparam int PREAMBLE_LEN = 32;
  localparam int PHY_W        = 5;
  localparam int REG_W        = 5;
  localparam int DATA_W       = 16;
  localparam int FRAME_LEN    = PREAMBLE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int TA_POS       = PREAMBLE_LEN + 4 + PHY_W + REG_W;
  localparam int DATA_POS     = TA_POS + 2;
  localparam int CNT_W        = $clog2(FRAME_LEN);

  // command word field positions
  localparam int REQ_BIT = 31;
  localparam int DIR_BIT = 30;
  localparam int PHY_LSB = 21;
  localparam int REG_LSB = 16;

  typedef struct packed {
    logic start;    // load a new frame
    logic capture;  // take one read data bit
    logic shift;    // advance to next frame bit
    logic finish;   // last bit period ends
  } mdioStrobes_t;

  function automatic logic [FRAME_LEN-1:0] buildFrame(input logic [31:0] cmd);
    logic isWr;
    isWr = cmd[DIR_BIT];
    return {{PREAMBLE_LEN{1'b1}}, 2'b01,
            (isWr ? 2'b01 : 2'b10),
            cmd[PHY_LSB +: PHY_W],
            cmd[REG_LSB +: REG_W],
            (isWr ? 2'b10 : 2'b11),
            (isWr ? cmd[DATA_W-1:0] : {DATA_W{1'b1}})};
  endfunction

endpackage

// File: rtl/mdio_bridge_ctrl.sv
module mdio_bridge_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         reqBit,
  input  logic         isWrite,
  output mdioStrobes_t strobes,
  output logic         busy,
  output logic         mdc,
  output logic         mdioOe
);

  localparam int PH_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TA_BIT    = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DATA_BIT  = CNT_W'(DATA_POS);

  logic             busyQ;
  logic             mdcHigh;
  logic [CNT_W-1:0] bitCnt;
  logic             phaseEnd;
  logic             startReq;

  assign startReq = regWrEn && reqBit && !busyQ;

  generate
    if (HALF_DIV == 1) begin : gNoDiv
      assign phaseEnd = 1'b1;
    end else begin : gDiv
      logic [PH_W-1:0] phaseCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          phaseCnt <= '0;
        end else if (startReq || phaseEnd) begin
          phaseCnt <= '0;
        end else if (busyQ) begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
      assign phaseEnd = (phaseCnt == PH_W'(HALF_DIV - 1));
    end
  endgenerate

  always_comb begin
    strobes.start   = startReq;
    strobes.capture = busyQ && phaseEnd && !mdcHigh && !isWrite && (bitCnt >= DATA_BIT);
    strobes.shift   = busyQ && phaseEnd && mdcHigh;
    strobes.finish  = busyQ && phaseEnd && mdcHigh && (bitCnt == LAST_BIT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      mdcHigh <= 1'b0;
      bitCnt  <= '0;
    end else if (startReq) begin
      busyQ   <= 1'b1;
      mdcHigh <= 1'b0;
      bitCnt  <= '0;
    end else if (busyQ && phaseEnd) begin
      mdcHigh <= !mdcHigh;
      if (mdcHigh) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) begin
          busyQ <= 1'b0;
        end
      end
    end
  end

  assign busy   = busyQ;
  assign mdc    = mdcHigh;
  assign mdioOe = busyQ && (isWrite || (bitCnt < TA_BIT));

  AST_MDC_LOW_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdc); // R7
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe); // R9
  AST_FINISH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> (!busy && !mdc)); // R2
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn) |=> busy || $past(strobes.finish)); // R8

endmodule

// File: rtl/mdio_bridge_dp.sv
module mdio_bridge_dp
  import mdio_bridge_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic [31:0]  regWrData,
  input  logic         busy,
  input  mdioStrobes_t strobes,
  input  logic         mdioIn,
  output logic [31:0]  cmdReg,
  output logic         isWrite,
  output logic         mdioOut
);

  logic [FRAME_LEN-1:0] frameSr;
  logic [DATA_W-1:0]    capSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (regWrEn && !busy) begin
      cmdReg <= regWrData;
    end else if (strobes.finish) begin
      cmdReg[REQ_BIT] <= 1'b0;
      if (!cmdReg[DIR_BIT]) begin
        cmdReg[DATA_W-1:0] <= capSr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
    end else if (strobes.start) begin
      frameSr <= buildFrame(regWrData);
    end else if (strobes.shift) begin
      frameSr <= {frameSr[FRAME_LEN-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSr <= '0;
    end else if (strobes.start) begin
      capSr <= '0;
    end else if (strobes.capture) begin
      capSr <= {capSr[DATA_W-2:0], mdioIn};
    end
  end

  assign isWrite = cmdReg[DIR_BIT];
  assign mdioOut = frameSr[FRAME_LEN-1];

  AST_REQ_TRACKS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    cmdReg[REQ_BIT] == busy); // R2
  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(cmdReg)); // R8

endmodule

// File: rtl/mdio_cmd_bridge.sv
module mdio_cmd_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  mdioStrobes_t strobes;
  logic         busy;
  logic         isWrite;

  mdio_bridge_ctrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .regWrEn (regWrEn),
    .reqBit  (regWrData[REQ_BIT]),
    .isWrite (isWrite),
    .strobes (strobes),
    .busy    (busy),
    .mdc     (mdc),
    .mdioOe  (mdioOe)
  );

  mdio_bridge_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .busy      (busy),
    .strobes   (strobes),
    .mdioIn    (mdioIn),
    .cmdReg    (regRdData),
    .isWrite   (isWrite),
    .mdioOut   (mdioOut)
  );

  AST_DATA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (mdc && $past(mdc)) |-> $stable(mdioOut)); // R7

endmodule

// File: tb/mdio_cmd_bridge_tb_top.sv
module mdio_cmd_bridge_tb_top;

  localparam int DIV    = 2;
  localparam int FRAMEB = 64;
  localparam int TXN    = FRAMEB * 2 * DIV;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn = 1'b1;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cyc = 0;

  // reference model state
  bit          mBusy = 0;
  int          mT = 0;
  logic [31:0] mReg = '0;
  logic [15:0] phyVal = 16'h0000;

  always #10 clk = !clk;

  mdio_cmd_bridge #(.HALF_DIV(DIV)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .mdioIn(mdioIn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit expBit(input logic [31:0] c, input int b);
    if (b < 32) return 1'b1;
    if (b == 32) return 1'b0;
    if (b == 33) return 1'b1;
    if (b == 34) return !c[30];
    if (b == 35) return c[30];
    if (b <= 40) return c[25 - (b - 36)];
    if (b <= 45) return c[20 - (b - 41)];
    if (b == 46) return 1'b1;
    if (b == 47) return 1'b0;
    return c[15 - (b - 48)];
  endfunction

  // model update at the active edge
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mBusy = 0; mT = 0; mReg = '0;
    end else if (mBusy) begin
      mT++;
      if (mT == TXN) begin
        mBusy = 0;
        mReg[31] = 1'b0;
        if (!mReg[30]) mReg[15:0] = phyVal;
      end
    end else if (regWrEn) begin
      mReg = regWrData;
      if (regWrData[31]) begin
        mBusy = 1; mT = 0;
      end
    end
  end

  // compare every cycle away from the edge, then drive the PHY side
  always @(negedge clk) begin
    if (rstN && !done) begin
      int b;
      bit oeE;
      b = mT / (2 * DIV);
      oeE = mBusy && (mReg[30] || b < 46);
      chk("R2 register", regRdData, mReg);
      chk("R7 mdc", {31'd0, mdc}, {31'd0, mBusy ? 1'(((mT / DIV) % 2)) : 1'b0});
      chk(mReg[30] ? "R4 oe" : "R5 oe", {31'd0, mdioOe}, {31'd0, oeE});
      if (oeE) chk(b < 46 ? "R3 frame bit" : "R4 write bit",
                   {31'd0, mdioOut}, {31'd0, expBit(mReg, b)});
      if (mBusy && !mReg[30] && b >= 48) mdioIn = phyVal[63 - b];
      else mdioIn = cyc[0];
    end
  end

  task automatic regWrite(input logic [31:0] v);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = 32'h0;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (regRdData[31] && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reg reset", regRdData, 32'h0);
    chk("R1 mdc reset", {31'd0, mdc}, 32'd0);
    chk("R1 oe reset", {31'd0, mdioOe}, 32'd0);

    // write frame: PHY 6, reg 0, value 0x9000
    regWrite(32'hC0C0_9000);
    chk("R2 busy flag", {31'd0, regRdData[31]}, 32'd1);
    waitIdle(n);
    chk("R2 duration", n, TXN);
    chk("R2 write result", regRdData, 32'h40C0_9000);

    // read frame, mixed pattern
    phyVal = 16'hA5C3;
    regWrite(32'h83F1_1234);
    waitIdle(n);
    chk("R6 read mixed", regRdData, 32'h03F1_A5C3);

    phyVal = 16'h0000;
    regWrite(32'h8000_FFFF);
    waitIdle(n);
    chk("R6 read zeros", regRdData, 32'h0000_0000);

    phyVal = 16'hFFFF;
    regWrite(32'h82AA_0000);
    waitIdle(n);
    chk("R6 read ones", regRdData, 32'h02AA_FFFF);

    // store without starting
    regWrite(32'h4123_ABCD);
    chk("R9 stored", regRdData, 32'h4123_ABCD);
    repeat (10) begin
      @(negedge clk);
      chk("R9 no mdc", {31'd0, mdc}, 32'd0);
      chk("R9 no drive", {31'd0, mdioOe}, 32'd0);
    end

    // write during busy is ignored
    phyVal = 16'h5A0F;
    regWrite(32'h80A2_0000);
    repeat (30) @(negedge clk);
    regWrite(32'hC0C0_9000);
    chk("R8 ignored", regRdData, 32'h80A2_0000);
    waitIdle(n);
    chk("R8 duration", n, TXN - 31);
    chk("R8 read result", regRdData, 32'h00A2_5A0F);

    // all-ones write with toggling mdioIn
    regWrite(32'hFFFF_FFFF);
    waitIdle(n);
    chk("R10 write kept", regRdData, 32'h7FFF_FFFF);
    chk("R7 idle mdc", {31'd0, mdc}, 32'd0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule